// File: doc/BRIEF.md
# Split Decade Counter With Gated Clear and Preset-to-Nine

This block is a four-bit counter built from two independent stages. A toggle stage produces the least significant output bit and advances on every falling transition of its own count input. A modulo-five stage produces the upper three output bits and advances on every falling transition of a second count input. When the second input is fed from the toggle stage's output, the four bits walk through the BCD digits zero to nine and then return to zero. The block can be used as one decade of a larger counter, or its two stages can be used separately as a divide-by-two and a divide-by-five.

Both count inputs are treated as ordinary data signals. A free-running system clock samples them through a synchroniser, and a falling-edge detector produces a one-cycle step request. No ripple clocks are used. A build parameter lets the modulo-five stage take its step directly from the toggle stage inside the block, so decade counting works without an external link. In that mode the second count input is ignored.

Two gated override functions act on the outputs without waiting for a clock edge. The clear function needs both of its enable pins high and forces 0000. The preset function needs both of its enable pins high and forces 1001. The preset wins over the clear. While either override is active, no counting takes place. When the override is released, the stored state keeps the forced value.

Top module: `bcd_split_counter`

## Requirements
- R1: Each falling transition of `tick_a` inverts `q_o[0]` (bit 0 of the output). A rising transition of `tick_a` leaves the output unchanged.
- R2: Each falling transition of `tick_b` steps `q_o[3:1]`, read as a binary number with `q_o[3]` as the most significant bit, through 0, 1, 2, 3, 4 and back to 0. A rising transition of `tick_b` leaves the output unchanged.
- R3: A counted transition on `tick_a` or `tick_b` appears at `q_o` no later than SYNC_STAGES+2 rising edges of `clk` after the input changes.
- R4: While `clr_a` and `clr_b` are both high and the preset is inactive, `q_o` is 0000, with no `clk` edge needed.
- R5: With only one of `clr_a`/`clr_b` high, or only one of `nine_a`/`nine_b` high, counting proceeds normally.
- R6: While `nine_a` and `nine_b` are both high, `q_o` is 1001, with no `clk` edge needed.
- R7: If the preset and the clear are both active, the output is 1001.
- R8: Falling transitions that arrive while the clear or the preset is active are not counted. After the override is released, the output holds the forced value until the next counted transition.
- R9: With `tick_b` driven from `q_o[0]` and counting applied to `tick_a`, the output follows 0,1,...,9 and then wraps to 0.
- R10: With CHAIN_INTERNAL=1, the modulo-five stage steps each time a counted `tick_a` transition takes `q_o[0]` from 1 to 0. In this mode `tick_b` has no effect on the output.
- R11: While `rst_n` is low, the stored count is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock that samples the count inputs |
| rst_n | input | 1 | Active-low system reset for the stored count and the synchronisers |
| tick_a | input | 1 | Count input of the toggle stage; counts on falling transitions |
| tick_b | input | 1 | Count input of the modulo-five stage; counts on falling transitions |
| clr_a | input | 1 | First enable of the gated clear |
| clr_b | input | 1 | Second enable of the gated clear |
| nine_a | input | 1 | First enable of the gated preset-to-nine |
| nine_b | input | 1 | Second enable of the gated preset-to-nine |
| q_o | output | 4 | Count output; q_o[0] from the toggle stage, q_o[3:1] from the modulo-five stage |

## Verification
Some properties are checked by assertions on every cycle. The forced values while either override is active, the preset winning over the clear, the upper field never leaving the range 0 to 4, and every change of the upper field outside an override being a single modulo-five step. Other behaviour can only be shown by the bench scenarios, which drive real input transitions. These cover the counting order through a full decade and its wrap, falling-edge-only counting, the single-pin cases that must not gate anything, and the state held after an override is released. The bench also shows that the external count input is ignored in the internal-link build.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    localparam int unsigned   HI_W       = 3;
    localparam logic [HI_W-1:0] HI_LAST  = 3'd4;
    localparam logic [3:0]    PRESET_VAL = 4'b1001;

    typedef struct packed {
        logic clr;
        logic nine;
        logic run;
    } ctl_t;

    typedef struct packed {
        logic [HI_W-1:0] hi;
    } hi_st_t;

    typedef struct packed {
        logic lo;
    } lo_st_t;

endpackage

// File: rtl/bsc_fall_sync.sv
module bsc_fall_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall_o
);
    logic [STAGES-1:0] sh_d, sh_q;
    logic              prev_d, prev_q;

    always_comb begin
        sh_d   = {sh_q[STAGES-2:0], din};
        prev_d = sh_q[STAGES-1];
        fall_o = prev_q & ~sh_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= sh_d;
            prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/bsc_div2.sv
module bsc_div2
    import bsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ctl_t ctl,
    input  logic step,
    output logic lo_o
);
    lo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl.nine)
            st_d.lo = PRESET_VAL[0];
        else if (ctl.clr)
            st_d.lo = 1'b0;
        else if (ctl.run && step)
            st_d.lo = ~st_q.lo;
        lo_o = st_q.lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bsc_div5.sv
module bsc_div5
    import bsc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  ctl_t            ctl,
    input  logic            step,
    output logic [HI_W-1:0] hi_o
);
    hi_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl.nine)
            st_d.hi = PRESET_VAL[3:1];
        else if (ctl.clr)
            st_d.hi = '0;
        else if (ctl.run && step)
            st_d.hi = (st_q.hi >= HI_LAST) ? '0 : st_q.hi + 1'b1;
        hi_o = st_q.hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bcd_split_counter.sv
module bcd_split_counter
    import bsc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES    = 2,
    parameter bit          CHAIN_INTERNAL = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_a,
    input  logic       tick_b,
    input  logic       clr_a,
    input  logic       clr_b,
    input  logic       nine_a,
    input  logic       nine_b,
    output logic [3:0] q_o
);
    localparam int unsigned N_IN = 2;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] fall;
    ctl_t            ctl;
    logic            lo_q;
    logic [HI_W-1:0] hi_q;
    logic            step_hi;

    assign raw_in = {tick_b, tick_a};

    for (genvar i = 0; i < N_IN; i++) begin : g_sync
        bsc_fall_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .din    (raw_in[i]),
            .fall_o (fall[i])
        );
    end

    always_comb begin
        ctl.nine = nine_a & nine_b;
        ctl.clr  = clr_a & clr_b;
        ctl.run  = ~ctl.nine & ~ctl.clr;
    end

    if (CHAIN_INTERNAL) begin : g_link
        assign step_hi = fall[0] & lo_q;
    end else begin : g_ext
        assign step_hi = fall[1];
    end

    bsc_div2 u_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ctl),
        .step  (fall[0]),
        .lo_o  (lo_q)
    );

    bsc_div5 u_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ctl),
        .step  (step_hi),
        .hi_o  (hi_q)
    );

    always_comb begin
        if (ctl.nine)      q_o = PRESET_VAL;
        else if (ctl.clr)  q_o = 4'b0000;
        else               q_o = {hi_q, lo_q};
    end
endmodule

// File: rtl/bcd_split_counter_chk.sv
module bcd_split_counter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clr_a,
    input logic       clr_b,
    input logic       nine_a,
    input logic       nine_b,
    input logic [3:0] q_o
);
    logic armed_q;
    logic frc;

    assign frc = (clr_a & clr_b) | (nine_a & nine_b);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_preset_nine_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (nine_a && nine_b) |-> (q_o == 4'b1001));

    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_a && clr_b && !(nine_a && nine_b)) |-> (q_o == 4'b0000));

    assert_preset_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_a && clr_b && nine_a && nine_b) |-> (q_o != 4'b0000));

    assert_hi_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (q_o[3:1] <= 3'd4));

    assert_hi_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !frc && $past(!frc) && (q_o[3:1] != $past(q_o[3:1])))
        |-> (q_o[3:1] == (($past(q_o[3:1]) == 3'd4) ? 3'd0 : $past(q_o[3:1]) + 3'd1)));
endmodule

bind bcd_split_counter bcd_split_counter_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_a  (clr_a),
    .clr_b  (clr_b),
    .nine_a (nine_a),
    .nine_b (nine_b),
    .q_o    (q_o)
);

// File: tb/test_bcd_split_counter.sv
module test_bcd_split_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_a = 1'b0;
    logic       tick_b_r = 1'b0;
    logic       ext_link = 1'b0;
    logic       clr_a = 1'b0, clr_b = 1'b0, nine_a = 1'b0, nine_b = 1'b0;
    logic [3:0] q, q2;
    logic       tick_b;
    int         total = 0, bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    assign tick_b = ext_link ? q[0] : tick_b_r;

    bcd_split_counter i_bcd_split_counter (
        .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
        .clr_a(clr_a), .clr_b(clr_b), .nine_a(nine_a), .nine_b(nine_b), .q_o(q));

    bcd_split_counter #(.CHAIN_INTERNAL(1'b1)) i_bcd_split_counter_lnk (
        .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b_r),
        .clr_a(clr_a), .clr_b(clr_b), .nine_a(nine_a), .nine_b(nine_b), .q_o(q2));

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_a();
        tick_a = 1'b1; wait_clk(8);
        tick_a = 1'b0; wait_clk(8);
    endtask

    task automatic pulse_b();
        tick_b_r = 1'b1; wait_clk(8);
        tick_b_r = 1'b0; wait_clk(8);
    endtask

    task automatic do_reset();
        @(negedge clk);
        ext_link = 1'b0; tick_a = 1'b0; tick_b_r = 1'b0;
        clr_a = 0; clr_b = 0; nine_a = 0; nine_b = 0;
        rst_n = 1'b0; wait_clk(3);
        check("R11 reset state", q, 4'b0000);
        check("R11 reset state link", q2, 4'b0000);
        rst_n = 1'b1; wait_clk(2);
    endtask

    task automatic t_div2();
        do_reset();
        tick_a = 1'b1; wait_clk(8);
        check("R1 rising edge ignored", q, 4'b0000);
        tick_a = 1'b0; wait_clk(4);
        check("R3 latency bound", q, 4'b0001);
        wait_clk(4);
        pulse_a();
        check("R1 second toggle", q, 4'b0000);
    endtask

    task automatic t_div5();
        do_reset();
        for (int k = 1; k <= 6; k++) begin
            pulse_b();
            check("R2 div5 step", q, {3'(k % 5), 1'b0});
        end
    endtask

    task automatic t_clear();
        do_reset();
        pulse_a(); pulse_b();
        check("R2 prep value", q, 4'b0011);
        clr_a = 1'b1; clr_b = 1'b1; #1;
        check("R4 immediate clear", q, 4'b0000);
        wait_clk(2);
        tick_a = 1'b1; wait_clk(8); tick_a = 1'b0; wait_clk(8);
        check("R8 no count while clear", q, 4'b0000);
        clr_a = 1'b0; clr_b = 1'b0; wait_clk(3);
        check("R8 clear held after release", q, 4'b0000);
    endtask

    task automatic t_single();
        do_reset();
        clr_a = 1'b1; nine_b = 1'b1;
        pulse_a(); pulse_b();
        check("R5 single pins do not gate", q, 4'b0011);
        clr_a = 1'b0; clr_b = 1'b1; nine_b = 1'b0; nine_a = 1'b1;
        pulse_a();
        check("R5 other single pins", q, 4'b0010);
        clr_b = 1'b0; nine_a = 1'b0;
    endtask

    task automatic t_nine();
        do_reset();
        nine_a = 1'b1; nine_b = 1'b1; #1;
        check("R6 immediate preset", q, 4'b1001);
        check("R6 immediate preset link", q2, 4'b1001);
        clr_a = 1'b1; clr_b = 1'b1; #1;
        check("R7 preset beats clear", q, 4'b1001);
        pulse_a();
        check("R8 no count while preset", q, 4'b1001);
        clr_a = 1'b0; clr_b = 1'b0; nine_a = 1'b0; nine_b = 1'b0; wait_clk(3);
        check("R8 preset held after release", q, 4'b1001);
    endtask

    task automatic t_decade_ext();
        do_reset();
        ext_link = 1'b1; wait_clk(2);
        for (int k = 1; k <= 12; k++) begin
            pulse_a();
            check("R9 decade order", q, 4'(k % 10));
        end
        ext_link = 1'b0;
    endtask

    task automatic t_decade_link();
        do_reset();
        for (int k = 1; k <= 11; k++) begin
            pulse_a();
            check("R10 internal link decade", q2, 4'(k % 10));
        end
    endtask

    task automatic t_link_ignore_b();
        do_reset();
        pulse_b(); pulse_b(); pulse_b();
        check("R10 tick_b ignored", q2, 4'b0000);
        check("R2 external stage stepped", q, 4'b0110);
    endtask

    initial begin
        fork
            begin
                t_div2();
                t_div5();
                t_clear();
                t_single();
                t_nine();
                t_decade_ext();
                t_decade_link();
                t_link_ignore_b();
                done = 1'b1;
            end
            begin
                wait_clk(150000);
                if (!done) begin
                    total++; bad++;
                    $display("FAIL watchdog got=hung expected=finish");
                end
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule